// File: doc/BRIEF.md
# Video Sample Range Protector

This block sits on the 8-bit sample path just ahead of a digital video stream formatter. The formatter uses the words 0x00 and 0xFF to mark timing reference headers. This block makes sure that no payload sample ever carries either of those words.

Each accepted sample is protected in one of two ways and then registered:

- **Clipping.** Outside the vertical-blanking data window, and inside it when the parity option is off, the sample is clipped into the legal range.
- **Parity substitution.** Inside the window, with the parity option on, the sample keeps its seven upper bits. Its lowest bit is replaced by a bit that gives the whole byte an odd number of ones. Under that rule neither reserved word can occur.

A single configuration input picks between the two window treatments. A window qualifier travels alongside each sample, and a valid strobe marks the samples to use. Output data and its valid flag appear one clock after the input.

Top module: `video_range_guard`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `out_valid` is 0 and `out_data` is 0x01.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: Clipping applies when the accepted sample is not in parity mode, meaning `in_vbi` and `cfg_parity` are not both 1. In that case an input of 0x00 becomes 0x01, an input of 0xFF becomes 0xFE, and every other value is passed unchanged to `out_data` one clock later.
- R4: When `in_valid`, `in_vbi` and `cfg_parity` are all 1, `out_data` one clock later holds `in_data[7:1]` in bits 7..1. Bit 0 is chosen so that the byte has an odd number of ones.
- R5: When `in_vbi` is 0, `cfg_parity` has no effect on `out_data`.
- R6: Whenever `out_valid` is 1, `out_data` is neither 0x00 nor 0xFF.
- R7: A clock edge with `in_valid` low leaves `out_data` unchanged.
- R8: `in_vbi` and `cfg_parity` are taken on the same edge as the sample they qualify. This holds even when they change on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Raw payload sample |
| in_vbi | input | 1 | Sample lies inside the vertical-blanking data window |
| cfg_parity | input | 1 | Selects parity substitution instead of clipping inside the window |
| out_valid | output | 1 | Output sample strobe, one clock after `in_valid` |
| out_data | output | 8 | Protected sample |

## Verification
A wrong treatment choice shows at `out_data` on the very next clock.

- A missed clip leaves a reserved word on the port.
- A wrong parity bit leaves a byte with an even number of ones.
- A qualifier sampled one edge late mislabels samples at once when the window toggles on every cycle.

A register that loads on idle edges shows up as a changed word during an invalid gap. The bench therefore compares every cycle against its model, across every input value in all four qualifier combinations.

// File: rtl/video_range_guard.sv
module video_range_guard #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_vbi,
  input  logic              cfg_parity,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [DATA_W-1:0] LO_CODE = '0;
  localparam logic [DATA_W-1:0] HI_CODE = '1;
  localparam logic [DATA_W-1:0] LO_SAFE = DATA_W'(1);
  localparam logic [DATA_W-1:0] HI_SAFE = HI_CODE - DATA_W'(1);

  logic              use_parity;
  logic              odd_bit;
  logic [DATA_W-1:0] clipped;
  logic [DATA_W-1:0] parity_word;
  logic [DATA_W-1:0] next_word;

  assign use_parity  = in_vbi & cfg_parity;
  assign odd_bit     = ~(^in_data[DATA_W-1:1]);
  assign parity_word = {in_data[DATA_W-1:1], odd_bit};
  assign clipped     = (in_data == LO_CODE) ? LO_SAFE :
                       (in_data == HI_CODE) ? HI_SAFE : in_data;
  assign next_word   = use_parity ? parity_word : clipped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= LO_SAFE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_word;
    end
  end
endmodule

// File: rtl/video_range_guard_chk.sv
module video_range_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_vbi,
  input logic              cfg_parity,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data != '0 && out_data != '1)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R7
  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vbi && cfg_parity) |=> (^out_data) == 1'b1); // R4
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_vbi && cfg_parity) |=> out_data[DATA_W-1:1] == $past(in_data[DATA_W-1:1])); // R4
  AST_MID_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(in_vbi && cfg_parity) && in_data != '0 && in_data != '1)
      |=> out_data == $past(in_data)); // R3
endmodule

bind video_range_guard video_range_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_vbi(in_vbi), .cfg_parity(cfg_parity),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_video_range_guard.sv
`timescale 1ns/1ps
module tb_video_range_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_vbi = 1'b0;
  logic       cfg_parity = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  string phase_tag = "R3";

  logic       m_valid = 1'b0;
  logic [7:0] m_data = 8'h01;
  string      m_tag = "R1";

  always #4 clk = ~clk;

  video_range_guard dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_vbi(in_vbi), .cfg_parity(cfg_parity),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [7:0] model(input int v, input bit vbi, input bit par);
    int ones = 0;
    if (vbi && par) begin
      for (int b = 1; b < 8; b++) ones += (v >> b) & 1;
      return 8'(((v / 2) * 2) + ((ones % 2 == 0) ? 1 : 0));
    end
    if (v == 0) return 8'd1;
    if (v == 255) return 8'd254;
    return 8'(v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= 8'h01;
      m_tag   <= "R1";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_data <= model(int'(in_data), in_vbi, cfg_parity);
        m_tag  <= phase_tag;
      end else begin
        m_tag  <= "R7";
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done && cycles > 1) begin
      check("R2", int'(out_valid), int'(m_valid));
      check(m_tag, int'(out_data), int'(m_data));
      if (out_valid) check("R6", int'(out_data == 8'h00 || out_data == 8'hFF), 0);
    end
  end

  task automatic drive(input bit v, input int d, input bit vbi, input bit par);
    @(negedge clk);
    in_valid = v; in_data = 8'(d); in_vbi = vbi; cfg_parity = par;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R3 clip path, R4 parity path, R5 parity option outside window
    for (int combo = 0; combo < 4; combo++) begin
      bit vbi = combo[1];
      bit par = combo[0];
      phase_tag = (vbi && par) ? "R4" : (!vbi && par) ? "R5" : "R3";
      for (int v = 0; v < 256; v++) begin
        drive(1'b1, v, vbi, par);
        if (v % 7 == 3) drive(1'b0, 255 - v, ~vbi, ~par); // R7 gap with noisy inputs
      end
    end
    // R8: qualifiers alternate every cycle
    phase_tag = "R8";
    for (int k = 0; k < 64; k++) drive(1'b1, (k * 37) & 255, k[0], 1'b1);
    for (int k = 0; k < 64; k++) drive(1'b1, (k * 53 + 1) & 255, 1'b1, k[0]);
    drive(1'b0, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset mid-stream returns to reset state
    rst_n = 1'b0;
    drive(1'b1, 8'hAA, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule